// File: doc/BRIEF.md
# ACPI Sleep-State Rail Sequencer

This controller decides which supply rails of a board are enabled, given the state of the standby bias, the soft-start handshake of the standby regulators and the two active-low sleep requests coming from the platform. Analog regulation is outside the block: a "bias good" level stands for the power-on-reset comparator and two "ramp done" levels stand for the end of each standby rail's soft-start. The outputs are digital enables for the 1.8V standby rail, the 3.3V dual/standby rail, the 5V dual rail, the memory rail and the clock regulator, plus the latched memory-voltage select and a 3-bit state code.

Once bias is good, the standby rails are started. When both report ramp done, a settle counter runs for a parameterised time (3 ms by default). At its end the memory select is captured and the remaining rails come up in the active state. From there the sleep requests move the block into suspend-to-RAM or soft-off and back. Three kinds of request are not honoured: a direct move between the two sleep states, the one forbidden request combination, and a change of the dual-rail configuration made while asleep.

States (code on `state_o`): OFF=0, STBY_RAMP=1, SETTLE=2, ACTIVE=3, SLEEP_S3=4, SLEEP_S5=5. Transitions: OFF→STBY_RAMP (bias good), STBY_RAMP→SETTLE (both ramps done, soft-start released), SETTLE→ACTIVE (settle count expired), ACTIVE→SLEEP_S3, ACTIVE→SLEEP_S5, SLEEP_S3→ACTIVE, SLEEP_S5→ACTIVE, any of SETTLE/ACTIVE/sleep→STBY_RAMP (soft-start held low), any→OFF (bias lost).

Top module: `rail_seq_ctrl`

## Requirements
- R1: While reset is asserted, or while `por_ok` is low, `state_o` is 0 (OFF) and every enable output and `mem_sel_o` is 0.
- R2: One clock after `por_ok` is sampled high in OFF, the state is STBY_RAMP (1) with `en_1v8_sb` and `en_3v3_dual` high; both stay high in every state for as long as `por_ok` stays high.
- R3: STBY_RAMP moves to SETTLE (2) only once both ramp-done inputs are high with `ss_n` high; SETTLE lasts exactly SETTLE_CYC = CLK_KHZ*SETTLE_US/1000 cycles and then becomes ACTIVE (3), capturing `mem_sel_cfg` into `mem_sel_o`.
- R4: In ACTIVE, `en_5v_dual`, `en_mem` and `en_clk` are all high.
- R5: `s5_n` and `s3_n` pass two synchronizer flops, so the state reacts on the third rising edge after they change. From ACTIVE, s5_n=1/s3_n=0 selects SLEEP_S3 (4) and s5_n=0/s3_n=0 selects SLEEP_S5 (5); s5_n=1/s3_n=1 returns either sleep state to ACTIVE.
- R6: In both sleep states `en_clk` is low; `en_mem` is high in SLEEP_S3 and low in SLEEP_S5.
- R7: The combination s5_n=0/s3_n=1 leaves the state unchanged in ACTIVE, SLEEP_S3 and SLEEP_S5.
- R8: A request for SLEEP_S5 while in SLEEP_S3, or for SLEEP_S3 while in SLEEP_S5, is ignored.
- R9: In the sleep states `en_5v_dual` equals the captured dual-rail configuration (1 = keep on). `dual_en_cfg` is captured in every state except the sleep states; a change made during sleep does not reach `en_5v_dual`.
- R10: With `ss_n` low in SETTLE, ACTIVE or a sleep state, the next state is STBY_RAMP, and it stays there while `ss_n` is low.
- R11: `por_ok` sampled low sends any state to OFF on the next edge and clears `mem_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Standby bias above power-on-reset level |
| ss_n | input | 1 | Soft-start release; low holds the block in shutdown |
| ramp_done_3v3 | input | 1 | 3.3V dual/standby rail finished its ramp |
| ramp_done_1v8 | input | 1 | 1.8V standby rail finished its ramp |
| s3_n | input | 1 | Active-low suspend-to-RAM request |
| s5_n | input | 1 | Active-low soft-off request |
| dual_en_cfg | input | 1 | Keep 5V dual rail on in sleep |
| mem_sel_cfg | input | 1 | Memory voltage selection |
| en_3v3_dual | output | 1 | Enable for 3.3V dual/standby rail |
| en_1v8_sb | output | 1 | Enable for 1.8V standby rail |
| en_5v_dual | output | 1 | Enable for 5V dual rail |
| en_mem | output | 1 | Enable for memory rail |
| en_clk | output | 1 | Enable for clock regulator |
| mem_sel_o | output | 1 | Captured memory voltage selection |
| state_o | output | 3 | Current state code |

## Verification
Bias, soft-start and ramp inputs act one clock edge after they are driven, while the sleep requests act on the third edge because of the synchronizer. The settle phase takes exactly SETTLE_CYC edges, and every output is decoded from the state register and the configuration latches without further delay. A behavioural model in the bench applies those same latencies and is compared with every output at each falling edge. The directed checks wait two edges to confirm that a sleep request has not yet acted, three edges to see it take effect, and five edges to confirm that an ignored request has changed nothing.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_STBY_RAMP = 3'd1,
        ST_SETTLE    = 3'd2,
        ST_ACTIVE    = 3'd3,
        ST_SLEEP_S3  = 3'd4,
        ST_SLEEP_S5  = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_RUN  = 2'd0,
        REQ_S3   = 2'd1,
        REQ_S5   = 2'd2,
        REQ_HOLD = 2'd3
    } sleep_req_e;

endpackage

// File: rtl/rail_sync2.sv
module rail_sync2 #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/rail_settle_timer.sv
module rail_settle_timer #(
    parameter int CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run && !done)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end
endmodule

// File: rtl/rail_sleep_decode.sv
module rail_sleep_decode
    import rail_seq_pkg::*;
(
    input  logic       s5_n_s,
    input  logic       s3_n_s,
    output sleep_req_e req
);
    always_comb begin
        unique case ({s5_n_s, s3_n_s})
            2'b11:   req = REQ_RUN;
            2'b10:   req = REQ_S3;
            2'b00:   req = REQ_S5;
            default: req = REQ_HOLD;
        endcase
    end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
    import rail_seq_pkg::*;
#(
    parameter int CLK_KHZ   = 100000,
    parameter int SETTLE_US = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_ok,
    input  logic       ss_n,
    input  logic       ramp_done_3v3,
    input  logic       ramp_done_1v8,
    input  logic       s3_n,
    input  logic       s5_n,
    input  logic       dual_en_cfg,
    input  logic       mem_sel_cfg,
    output logic       en_3v3_dual,
    output logic       en_1v8_sb,
    output logic       en_5v_dual,
    output logic       en_mem,
    output logic       en_clk,
    output logic       mem_sel_o,
    output logic [2:0] state_o
);
    localparam int SETTLE_CYC = (CLK_KHZ * SETTLE_US) / 1000;

    seq_state_e state_q, state_d;
    sleep_req_e req;
    logic [1:0] sleep_s;
    logic       settle_done;
    logic       dual_q;
    logic       msel_q;
    logic       in_sleep;

    rail_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({s5_n, s3_n}),
        .q     (sleep_s)
    );

    rail_sleep_decode u_dec (
        .s5_n_s (sleep_s[1]),
        .s3_n_s (sleep_s[0]),
        .req    (req)
    );

    rail_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SETTLE),
        .done  (settle_done)
    );

    assign in_sleep = (state_q == ST_SLEEP_S3) || (state_q == ST_SLEEP_S5);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:       if (por_ok) state_d = ST_STBY_RAMP;
            ST_STBY_RAMP: if (ss_n && ramp_done_3v3 && ramp_done_1v8) state_d = ST_SETTLE;
            ST_SETTLE:    if (settle_done) state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (req == REQ_S3)      state_d = ST_SLEEP_S3;
                else if (req == REQ_S5) state_d = ST_SLEEP_S5;
            end
            ST_SLEEP_S3:  if (req == REQ_RUN) state_d = ST_ACTIVE;
            ST_SLEEP_S5:  if (req == REQ_RUN) state_d = ST_ACTIVE;
            default:      state_d = ST_OFF;
        endcase
        if (!ss_n && (state_q != ST_OFF) && (state_q != ST_STBY_RAMP))
            state_d = ST_STBY_RAMP;
        if (!por_ok)
            state_d = ST_OFF;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // configuration latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dual_q <= 1'b0;
            msel_q <= 1'b0;
        end else begin
            if (!in_sleep)
                dual_q <= dual_en_cfg;
            if (!por_ok)
                msel_q <= 1'b0;
            else if ((state_q == ST_SETTLE) && settle_done && ss_n)
                msel_q <= mem_sel_cfg;
        end
    end

    // output decode
    always_comb begin
        en_3v3_dual = 1'b0;
        en_1v8_sb   = 1'b0;
        en_5v_dual  = 1'b0;
        en_mem      = 1'b0;
        en_clk      = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_STBY_RAMP, ST_SETTLE: begin
                en_3v3_dual = 1'b1;
                en_1v8_sb   = 1'b1;
            end
            ST_ACTIVE: begin
                en_3v3_dual = 1'b1;
                en_1v8_sb   = 1'b1;
                en_5v_dual  = 1'b1;
                en_mem      = 1'b1;
                en_clk      = 1'b1;
            end
            ST_SLEEP_S3: begin
                en_3v3_dual = 1'b1;
                en_1v8_sb   = 1'b1;
                en_5v_dual  = dual_q;
                en_mem      = 1'b1;
            end
            ST_SLEEP_S5: begin
                en_3v3_dual = 1'b1;
                en_1v8_sb   = 1'b1;
                en_5v_dual  = dual_q;
            end
            default: ;
        endcase
    end

    assign mem_sel_o = msel_q;
    assign state_o   = state_q;

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_ok,
    input logic       ss_n,
    input logic       en_1v8_sb,
    input logic       en_clk,
    input logic       en_5v_dual,
    input logic       mem_sel_o,
    input logic [2:0] state_o
);
    p_por_loss_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (state_o == 3'd0) && !mem_sel_o);

    p_1v8_follows_bias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        por_ok |=> en_1v8_sb);

    p_no_s3_to_s5_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o != 3'd5));

    p_no_s5_to_s3_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5) |=> (state_o != 3'd4));

    p_clk_off_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd4) || (state_o == 3'd5)) |-> !en_clk);

    p_dual_frozen_s3_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd4) && ($past(state_o) == 3'd4)) |-> $stable(en_5v_dual));

    p_dual_frozen_s5_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd5) && ($past(state_o) == 3'd5)) |-> $stable(en_5v_dual));

    p_shutdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && por_ok && (state_o >= 3'd2)) |=> (state_o == 3'd1));
endmodule

bind rail_seq_ctrl rail_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_ok     (por_ok),
    .ss_n       (ss_n),
    .en_1v8_sb  (en_1v8_sb),
    .en_clk     (en_clk),
    .en_5v_dual (en_5v_dual),
    .mem_sel_o  (mem_sel_o),
    .state_o    (state_o)
);

// File: tb/rail_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rail_seq_ctrl_tb_top;
    localparam int N = 100;   // settle cycles: 100000 kHz * 1 us

    logic clk = 1'b0;
    logic rst_n, por_ok, ss_n, rd3, rd1, s3_n, s5_n, dual_en_cfg, mem_sel_cfg;
    logic en_3v3_dual, en_1v8_sb, en_5v_dual, en_mem, en_clk, mem_sel_o;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rail_seq_ctrl #(.CLK_KHZ(100000), .SETTLE_US(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .ss_n(ss_n),
        .ramp_done_3v3(rd3), .ramp_done_1v8(rd1), .s3_n(s3_n), .s5_n(s5_n),
        .dual_en_cfg(dual_en_cfg), .mem_sel_cfg(mem_sel_cfg),
        .en_3v3_dual(en_3v3_dual), .en_1v8_sb(en_1v8_sb), .en_5v_dual(en_5v_dual),
        .en_mem(en_mem), .en_clk(en_clk), .mem_sel_o(mem_sel_o), .state_o(state_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_st, m_cnt, m_ns;
    bit m_dual, m_msel;
    bit [1:0] m_q1, m_q2;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_dual = 0; m_msel = 0; m_q1 = 2'b11; m_q2 = 2'b11;
        end else begin
            m_ns = m_st;
            case (m_st)
                0: if (por_ok) m_ns = 1;
                1: if (ss_n && rd3 && rd1) m_ns = 2;
                2: if (m_cnt == N - 1) m_ns = 3;
                3: if (m_q2 == 2'b10) m_ns = 4; else if (m_q2 == 2'b00) m_ns = 5;
                4: if (m_q2 == 2'b11) m_ns = 3;
                5: if (m_q2 == 2'b11) m_ns = 3;
                default: m_ns = 0;
            endcase
            if (m_st >= 2 && !ss_n) m_ns = 1;
            if (!por_ok) m_ns = 0;
            if (m_st < 4) m_dual = dual_en_cfg;
            if (!por_ok) m_msel = 0;
            else if (m_st == 2 && m_cnt == N - 1 && ss_n) m_msel = mem_sel_cfg;
            m_cnt = (m_st == 2 && m_cnt != N - 1) ? m_cnt + 1 : 0;
            m_q2 = m_q1;
            m_q1 = {s5_n, s3_n};
            m_st = m_ns;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5/R7/R8 state", state_o, m_st);
            chk("R2 en_1v8_sb", en_1v8_sb, m_st != 0);
            chk("R2 en_3v3_dual", en_3v3_dual, m_st != 0);
            chk("R9 en_5v_dual", en_5v_dual, (m_st == 3) || ((m_st >= 4) && m_dual));
            chk("R6 en_mem", en_mem, (m_st == 3) || (m_st == 4));
            chk("R4 en_clk", en_clk, m_st == 3);
            chk("R3 mem_sel_o", mem_sel_o, m_msel);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int len;
        rst_n = 0; por_ok = 0; ss_n = 1; rd3 = 0; rd1 = 0;
        s3_n = 1; s5_n = 1; dual_en_cfg = 1; mem_sel_cfg = 1;
        cyc(3);
        chk("R1 state in reset", state_o, 0);
        chk("R1 enables in reset", {en_3v3_dual, en_1v8_sb, en_5v_dual, en_mem, en_clk, mem_sel_o}, 0);
        rst_n = 1;
        cyc(2);
        chk("R1 off while bias low", state_o, 0);
        chk("R1 rails off while bias low", {en_3v3_dual, en_1v8_sb, en_clk}, 0);

        por_ok = 1;
        cyc(1);
        chk("R2 stby ramp", state_o, 1);
        chk("R2 standby enables", {en_1v8_sb, en_3v3_dual}, 2'b11);
        cyc(4);
        rd3 = 1;
        cyc(2);
        chk("R3 waits for both ramps", state_o, 1);
        rd1 = 1;
        cyc(1);
        len = 0;
        while (state_o == 3'd2 && len < 1000) begin
            len++;
            cyc(1);
        end
        chk("R3 settle length", len, N);
        chk("R3 active after settle", state_o, 3);
        chk("R3 mem_sel captured", mem_sel_o, 1);
        chk("R4 active enables", {en_5v_dual, en_mem, en_clk}, 3'b111);

        s3_n = 0;
        cyc(2);
        chk("R5 not yet through sync", state_o, 3);
        cyc(1);
        chk("R5 enter S3", state_o, 4);
        chk("R6 S3 clk off", en_clk, 0);
        chk("R6 S3 mem on", en_mem, 1);
        chk("R9 S3 dual kept on", en_5v_dual, 1);
        dual_en_cfg = 0;
        cyc(3);
        chk("R9 cfg change in sleep ignored", en_5v_dual, 1);
        s5_n = 0;
        cyc(5);
        chk("R8 S3 to S5 blocked", state_o, 4);
        s3_n = 1;
        cyc(5);
        chk("R7 hold in S3", state_o, 4);
        s5_n = 1;
        cyc(5);
        chk("R5 wake from S3", state_o, 3);

        s5_n = 0; s3_n = 0;
        cyc(5);
        chk("R5 enter S5", state_o, 5);
        chk("R9 S5 dual off after accepted change", en_5v_dual, 0);
        chk("R6 S5 mem off", en_mem, 0);
        chk("R6 S5 clk off", en_clk, 0);
        s5_n = 1;
        cyc(5);
        chk("R8 S5 to S3 blocked", state_o, 5);
        s3_n = 1;
        cyc(5);
        chk("R5 wake from S5", state_o, 3);
        s5_n = 0;
        cyc(5);
        chk("R7 hold in active", state_o, 3);
        s5_n = 1;
        cyc(4);

        ss_n = 0;
        cyc(1);
        chk("R10 shutdown to stby", state_o, 1);
        chk("R10 clk off in shutdown", en_clk, 0);
        dual_en_cfg = 1;
        cyc(5);
        chk("R10 held while ss low", state_o, 1);
        ss_n = 1;
        cyc(1);
        chk("R10 resettle", state_o, 2);
        cyc(N);
        chk("R10 active again", state_o, 3);

        por_ok = 0;
        cyc(1);
        chk("R11 bias loss to off", state_o, 0);
        chk("R11 mem_sel cleared", mem_sel_o, 0);
        chk("R11 standby rail off", en_1v8_sb, 0);
        cyc(2);
        finish_run();
    end
endmodule